// File: doc/BRIEF.md
# Predicate-Filtering Dispatch Stage

This block is the dispatch stage of a small VLIW pipeline. Each cycle it takes a bundle of operation slots, and a bundle may hold more operations of one class than there are functional units of that class. Every operation names a guard predicate. The stage reads its own predicate register file before decode. Adder-class and multiplier-class operations whose guard reads false are squashed, so they never claim a unit. The survivors are packed onto the unit ports of their class, and each unit gets a one-hot slot grant together with the forwarded operands.

The stage also executes predicate-define operations. Each one compares two operands and writes a complementary pair of predicates. A compiler can therefore place operations from mutually exclusive control paths in one bundle, and only the path that is live consumes a unit. All outputs are registered. They describe the bundle that was presented in the previous cycle.

Top module: `pfd_dispatch`

## Requirements
- R1: After reset every output is low, and every predicate other than index 0 reads false.
- R2: A valid adder-class (kind 0) or multiplier-class (kind 1) operation whose guard predicate is false gets no unit grant. Its bit in squash_o is set in the cycle after the bundle is presented.
- R3: Predicate index 0 always reads true. Predicate-define writes that target index 0 are ignored.
- R4: A predicate-define (kind 2) with a true guard writes its taken-side target with the comparison result and its not-taken-side target with the complement. Compare code 0 tests equality; compare code 1 tests unsigned operand A less than operand B.
- R5: A predicate-define whose guard is false writes false to both of its targets.
- R6: A predicate written by a bundle presented in cycle N guards bundles from cycle N+2 on. The bundle of cycle N+1 still sees the old value.
- R7: Surviving operations of a class are given to that class's units in ascending slot order, starting at unit 0. Unit u's grant is one-hot at bit position equal to the slot index, and the unit carries that slot's two operands.
- R8: Each unit receives at most one operation per cycle, and no slot is granted to more than one unit.
- R9: When more true-guarded operations of a class arrive than there are units of that class, the highest-numbered excess slots are dropped. Their bits are set in drop_o, and oversub_o is raised.
- R10: Predicate-define operations and kind 3 (no-op) never claim a unit and are never squashed or dropped.
- R11: When one bundle writes the same predicate several times, the write from the highest slot wins. Within one slot, the not-taken-side write wins over the taken-side write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | NUM_SLOTS | Slot holds an operation |
| slot_kind_i | input | 2*NUM_SLOTS | Kind per slot: 0 add, 1 mul, 2 predicate define, 3 no-op |
| slot_guard_i | input | PW*NUM_SLOTS | Guard predicate index per slot |
| slot_dst_t_i | input | PW*NUM_SLOTS | Taken-side predicate target |
| slot_dst_f_i | input | PW*NUM_SLOTS | Not-taken-side predicate target |
| slot_cmp_i | input | NUM_SLOTS | Compare code: 0 equal, 1 unsigned less |
| slot_opa_i | input | DW*NUM_SLOTS | Operand A per slot |
| slot_opb_i | input | DW*NUM_SLOTS | Operand B per slot |
| add_valid_o | output | NUM_ADD | Adder unit has an operation |
| add_grant_o | output | NUM_ADD*NUM_SLOTS | One-hot source slot per adder unit |
| add_opa_o | output | NUM_ADD*DW | Operand A per adder unit |
| add_opb_o | output | NUM_ADD*DW | Operand B per adder unit |
| mul_valid_o | output | NUM_MUL | Multiplier unit has an operation |
| mul_grant_o | output | NUM_MUL*NUM_SLOTS | One-hot source slot per multiplier unit |
| mul_opa_o | output | NUM_MUL*DW | Operand A per multiplier unit |
| mul_opb_o | output | NUM_MUL*DW | Operand B per multiplier unit |
| squash_o | output | NUM_SLOTS | Slot squashed by a false guard |
| drop_o | output | NUM_SLOTS | Slot dropped for lack of a unit |
| oversub_o | output | 1 | A class was oversubscribed |

## Verification
A corrupted predicate bit shows up only when a later bundle is guarded by it. It then appears as a wrong squash_o bit or a missing grant, one cycle after that bundle. The bench therefore reads every predicate it writes back through guarded adds, two cycles after the write. A packing fault shows up in the very next cycle as a non-one-hot grant, a grant out of slot order, or a slot granted twice. The checker flags that shape on every cycle, and the stimulus table checks the exact values.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    KIND_ADD  = 2'd0,
    KIND_MUL  = 2'd1,
    KIND_PDEF = 2'd2,
    KIND_NONE = 2'd3
  } op_kind_e;

  localparam logic CMP_EQ  = 1'b0;
  localparam logic CMP_ULT = 1'b1;
endpackage

// File: rtl/pfd_pred_file.sv
module pfd_pred_file #(
  parameter int NUM_PREDS = 8,
  parameter int NUM_WR    = 8,
  localparam int PW = $clog2(NUM_PREDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WR-1:0]    wr_en_i,
  input  logic [NUM_WR*PW-1:0] wr_idx_i,
  input  logic [NUM_WR-1:0]    wr_val_i,
  output logic [NUM_PREDS-1:0] pred_o
);
  // staging register adds the extra cycle of define-to-use latency
  logic [NUM_WR-1:0]    stg_en_q;
  logic [NUM_WR*PW-1:0] stg_idx_q;
  logic [NUM_WR-1:0]    stg_val_q;
  logic [NUM_PREDS-1:1] pred_q, pred_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_en_q  <= '0;
      stg_idx_q <= '0;
      stg_val_q <= '0;
    end else begin
      stg_en_q  <= wr_en_i;
      stg_idx_q <= wr_idx_i;
      stg_val_q <= wr_val_i;
    end
  end

  // ascending write order: later entries override earlier ones
  always_comb begin
    pred_d = pred_q;
    for (int p = 1; p < NUM_PREDS; p++) begin
      for (int w = 0; w < NUM_WR; w++) begin
        if (stg_en_q[w] && (int'(stg_idx_q[w*PW +: PW]) == p)) pred_d[p] = stg_val_q[w];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pred_q <= '0;
    else         pred_q <= pred_d;
  end

  assign pred_o = {pred_q, 1'b1};
endmodule

// File: rtl/pfd_guard_eval.sv
module pfd_guard_eval
  import pfd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_PREDS = 8,
  parameter int DW        = 8,
  localparam int PW = $clog2(NUM_PREDS)
) (
  input  logic [NUM_PREDS-1:0]   pred_i,
  input  logic [NUM_SLOTS-1:0]   slot_valid_i,
  input  logic [2*NUM_SLOTS-1:0] slot_kind_i,
  input  logic [PW*NUM_SLOTS-1:0] slot_guard_i,
  input  logic [PW*NUM_SLOTS-1:0] slot_dst_t_i,
  input  logic [PW*NUM_SLOTS-1:0] slot_dst_f_i,
  input  logic [NUM_SLOTS-1:0]   slot_cmp_i,
  input  logic [DW*NUM_SLOTS-1:0] slot_opa_i,
  input  logic [DW*NUM_SLOTS-1:0] slot_opb_i,
  output logic [NUM_SLOTS-1:0]   add_req_o,
  output logic [NUM_SLOTS-1:0]   mul_req_o,
  output logic [NUM_SLOTS-1:0]   squash_o,
  output logic [2*NUM_SLOTS-1:0] wr_en_o,
  output logic [2*NUM_SLOTS*PW-1:0] wr_idx_o,
  output logic [2*NUM_SLOTS-1:0] wr_val_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    op_kind_e kind;
    logic     guard_ok, is_unit, cmp_res;
    logic [DW-1:0] a, b;

    assign kind     = op_kind_e'(slot_kind_i[2*s +: 2]);
    assign guard_ok = pred_i[slot_guard_i[PW*s +: PW]];
    assign a        = slot_opa_i[DW*s +: DW];
    assign b        = slot_opb_i[DW*s +: DW];
    assign is_unit  = slot_valid_i[s] && (kind == KIND_ADD || kind == KIND_MUL);
    assign cmp_res  = (slot_cmp_i[s] == CMP_ULT) ? (a < b) : (a == b);

    assign add_req_o[s] = slot_valid_i[s] && kind == KIND_ADD && guard_ok;
    assign mul_req_o[s] = slot_valid_i[s] && kind == KIND_MUL && guard_ok;
    assign squash_o[s]  = is_unit && !guard_ok;

    // entry 2s: taken side, entry 2s+1: not-taken side (later wins)
    assign wr_en_o[2*s]   = slot_valid_i[s] && kind == KIND_PDEF;
    assign wr_en_o[2*s+1] = slot_valid_i[s] && kind == KIND_PDEF;
    assign wr_idx_o[PW*(2*s) +: PW]   = slot_dst_t_i[PW*s +: PW];
    assign wr_idx_o[PW*(2*s+1) +: PW] = slot_dst_f_i[PW*s +: PW];
    assign wr_val_o[2*s]   = guard_ok &&  cmp_res;
    assign wr_val_o[2*s+1] = guard_ok && !cmp_res;
  end
endmodule

// File: rtl/pfd_unit_packer.sv
module pfd_unit_packer #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_UNITS = 2
) (
  input  logic [NUM_SLOTS-1:0]           req_i,
  output logic [NUM_UNITS*NUM_SLOTS-1:0] grant_o,
  output logic [NUM_UNITS-1:0]           valid_o,
  output logic [NUM_SLOTS-1:0]           drop_o
);
  always_comb begin
    int cnt;
    cnt     = 0;
    grant_o = '0;
    drop_o  = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (req_i[s]) begin
        if (cnt < NUM_UNITS) begin
          grant_o[cnt*NUM_SLOTS + s] = 1'b1;
          cnt = cnt + 1;
        end else begin
          drop_o[s] = 1'b1;
        end
      end
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_valid
    assign valid_o[u] = |grant_o[u*NUM_SLOTS +: NUM_SLOTS];
  end
endmodule

// File: rtl/pfd_dispatch.sv
module pfd_dispatch #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_ADD   = 2,
  parameter int NUM_MUL   = 1,
  parameter int NUM_PREDS = 8,
  parameter int DW        = 8,
  localparam int PW = $clog2(NUM_PREDS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SLOTS-1:0]       slot_valid_i,
  input  logic [2*NUM_SLOTS-1:0]     slot_kind_i,
  input  logic [PW*NUM_SLOTS-1:0]    slot_guard_i,
  input  logic [PW*NUM_SLOTS-1:0]    slot_dst_t_i,
  input  logic [PW*NUM_SLOTS-1:0]    slot_dst_f_i,
  input  logic [NUM_SLOTS-1:0]       slot_cmp_i,
  input  logic [DW*NUM_SLOTS-1:0]    slot_opa_i,
  input  logic [DW*NUM_SLOTS-1:0]    slot_opb_i,
  output logic [NUM_ADD-1:0]         add_valid_o,
  output logic [NUM_ADD*NUM_SLOTS-1:0] add_grant_o,
  output logic [NUM_ADD*DW-1:0]      add_opa_o,
  output logic [NUM_ADD*DW-1:0]      add_opb_o,
  output logic [NUM_MUL-1:0]         mul_valid_o,
  output logic [NUM_MUL*NUM_SLOTS-1:0] mul_grant_o,
  output logic [NUM_MUL*DW-1:0]      mul_opa_o,
  output logic [NUM_MUL*DW-1:0]      mul_opb_o,
  output logic [NUM_SLOTS-1:0]       squash_o,
  output logic [NUM_SLOTS-1:0]       drop_o,
  output logic                       oversub_o
);
  localparam int NUM_WR = 2 * NUM_SLOTS;

  logic [NUM_PREDS-1:0]   pred;
  logic [NUM_SLOTS-1:0]   add_req, mul_req, squash, add_drop, mul_drop;
  logic [NUM_WR-1:0]      wr_en, wr_val;
  logic [NUM_WR*PW-1:0]   wr_idx;
  logic [NUM_ADD*NUM_SLOTS-1:0] add_grant;
  logic [NUM_MUL*NUM_SLOTS-1:0] mul_grant;
  logic [NUM_ADD-1:0]     add_valid;
  logic [NUM_MUL-1:0]     mul_valid;
  logic [NUM_ADD*DW-1:0]  add_opa, add_opb;
  logic [NUM_MUL*DW-1:0]  mul_opa, mul_opb;

  pfd_pred_file #(.NUM_PREDS(NUM_PREDS), .NUM_WR(NUM_WR)) i_pred_file (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_val_i (wr_val),
    .pred_o   (pred)
  );

  pfd_guard_eval #(.NUM_SLOTS(NUM_SLOTS), .NUM_PREDS(NUM_PREDS), .DW(DW)) i_guard_eval (
    .pred_i       (pred),
    .slot_valid_i (slot_valid_i),
    .slot_kind_i  (slot_kind_i),
    .slot_guard_i (slot_guard_i),
    .slot_dst_t_i (slot_dst_t_i),
    .slot_dst_f_i (slot_dst_f_i),
    .slot_cmp_i   (slot_cmp_i),
    .slot_opa_i   (slot_opa_i),
    .slot_opb_i   (slot_opb_i),
    .add_req_o    (add_req),
    .mul_req_o    (mul_req),
    .squash_o     (squash),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_val_o     (wr_val)
  );

  pfd_unit_packer #(.NUM_SLOTS(NUM_SLOTS), .NUM_UNITS(NUM_ADD)) i_add_packer (
    .req_i   (add_req),
    .grant_o (add_grant),
    .valid_o (add_valid),
    .drop_o  (add_drop)
  );

  pfd_unit_packer #(.NUM_SLOTS(NUM_SLOTS), .NUM_UNITS(NUM_MUL)) i_mul_packer (
    .req_i   (mul_req),
    .grant_o (mul_grant),
    .valid_o (mul_valid),
    .drop_o  (mul_drop)
  );

  // operand steering: AND-OR over one-hot grants
  for (genvar u = 0; u < NUM_ADD; u++) begin : g_add_mux
    always_comb begin
      add_opa[u*DW +: DW] = '0;
      add_opb[u*DW +: DW] = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        add_opa[u*DW +: DW] |= {DW{add_grant[u*NUM_SLOTS + s]}} & slot_opa_i[s*DW +: DW];
        add_opb[u*DW +: DW] |= {DW{add_grant[u*NUM_SLOTS + s]}} & slot_opb_i[s*DW +: DW];
      end
    end
  end

  for (genvar u = 0; u < NUM_MUL; u++) begin : g_mul_mux
    always_comb begin
      mul_opa[u*DW +: DW] = '0;
      mul_opb[u*DW +: DW] = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        mul_opa[u*DW +: DW] |= {DW{mul_grant[u*NUM_SLOTS + s]}} & slot_opa_i[s*DW +: DW];
        mul_opb[u*DW +: DW] |= {DW{mul_grant[u*NUM_SLOTS + s]}} & slot_opb_i[s*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_valid_o <= '0;
      add_grant_o <= '0;
      add_opa_o   <= '0;
      add_opb_o   <= '0;
      mul_valid_o <= '0;
      mul_grant_o <= '0;
      mul_opa_o   <= '0;
      mul_opb_o   <= '0;
      squash_o    <= '0;
      drop_o      <= '0;
      oversub_o   <= 1'b0;
    end else begin
      add_valid_o <= add_valid;
      add_grant_o <= add_grant;
      add_opa_o   <= add_opa;
      add_opb_o   <= add_opb;
      mul_valid_o <= mul_valid;
      mul_grant_o <= mul_grant;
      mul_opa_o   <= mul_opa;
      mul_opb_o   <= mul_opb;
      squash_o    <= squash;
      drop_o      <= add_drop | mul_drop;
      oversub_o   <= (|add_drop) | (|mul_drop);
    end
  end
endmodule

// File: rtl/pfd_dispatch_chk.sv
module pfd_dispatch_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_ADD   = 2,
  parameter int NUM_MUL   = 1
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_SLOTS-1:0]           slot_valid_i,
  input logic [2*NUM_SLOTS-1:0]         slot_kind_i,
  input logic [NUM_ADD-1:0]             add_valid_o,
  input logic [NUM_ADD*NUM_SLOTS-1:0]   add_grant_o,
  input logic [NUM_MUL-1:0]             mul_valid_o,
  input logic [NUM_MUL*NUM_SLOTS-1:0]   mul_grant_o,
  input logic [NUM_SLOTS-1:0]           squash_o,
  input logic [NUM_SLOTS-1:0]           drop_o,
  input logic                           oversub_o
);
  localparam int NU = NUM_ADD + NUM_MUL;

  for (genvar u = 0; u < NUM_ADD; u++) begin : g_add
    AST_ADD_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(add_grant_o[u*NUM_SLOTS +: NUM_SLOTS]) &&
      (add_valid_o[u] == (add_grant_o[u*NUM_SLOTS +: NUM_SLOTS] != '0))); // R7
  end

  for (genvar u = 0; u < NUM_MUL; u++) begin : g_mul
    AST_MUL_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(mul_grant_o[u*NUM_SLOTS +: NUM_SLOTS]) &&
      (mul_valid_o[u] == (mul_grant_o[u*NUM_SLOTS +: NUM_SLOTS] != '0))); // R7
  end

  for (genvar u = 0; u + 1 < NUM_ADD; u++) begin : g_add_order
    AST_ADD_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      add_valid_o[u+1] |-> add_valid_o[u] &&
      (add_grant_o[u*NUM_SLOTS +: NUM_SLOTS] < add_grant_o[(u+1)*NUM_SLOTS +: NUM_SLOTS])); // R7
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [NU-1:0] col;
    for (genvar u = 0; u < NUM_ADD; u++) begin : g_ca
      assign col[u] = add_grant_o[u*NUM_SLOTS + s];
    end
    for (genvar u = 0; u < NUM_MUL; u++) begin : g_cm
      assign col[NUM_ADD+u] = mul_grant_o[u*NUM_SLOTS + s];
    end

    AST_SLOT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(col) <= 1); // R8
    AST_SQUASH_NO_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      squash_o[s] |-> (col == '0) && !drop_o[s]); // R2
    AST_DROP_NO_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_o[s] |-> (col == '0) && oversub_o); // R9
    AST_PDEF_NO_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_valid_i[s] && slot_kind_i[2*s +: 2] >= 2'd2) |=>
      (col == '0) && !squash_o[s] && !drop_o[s]); // R10
  end

  AST_OVERSUB_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oversub_o |-> (&add_valid_o) || (&mul_valid_o)); // R9
endmodule

bind pfd_dispatch pfd_dispatch_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_ADD(NUM_ADD), .NUM_MUL(NUM_MUL)
) i_pfd_dispatch_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_valid_i (slot_valid_i),
  .slot_kind_i  (slot_kind_i),
  .add_valid_o  (add_valid_o),
  .add_grant_o  (add_grant_o),
  .mul_valid_o  (mul_valid_o),
  .mul_grant_o  (mul_grant_o),
  .squash_o     (squash_o),
  .drop_o       (drop_o),
  .oversub_o    (oversub_o)
);

// File: tb/test_pfd_dispatch.sv
module test_pfd_dispatch;
  localparam int NS = 4, NA = 2, NM = 1, NP = 8, DW = 8, PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NS-1:0]    v;
  logic [2*NS-1:0]  k;
  logic [PW*NS-1:0] g, dt, df;
  logic [NS-1:0]    c;
  logic [DW*NS-1:0] a, b;
  logic [NA-1:0]    add_valid;
  logic [NA*NS-1:0] add_grant;
  logic [NA*DW-1:0] add_opa, add_opb;
  logic [NM-1:0]    mul_valid;
  logic [NM*NS-1:0] mul_grant;
  logic [NM*DW-1:0] mul_opa, mul_opb;
  logic [NS-1:0]    squash, drop;
  logic             oversub;

  pfd_dispatch #(.NUM_SLOTS(NS), .NUM_ADD(NA), .NUM_MUL(NM), .NUM_PREDS(NP), .DW(DW)) i_pfd_dispatch (
    .clk_i(clk), .rst_ni(rst_n),
    .slot_valid_i(v), .slot_kind_i(k), .slot_guard_i(g),
    .slot_dst_t_i(dt), .slot_dst_f_i(df), .slot_cmp_i(c),
    .slot_opa_i(a), .slot_opb_i(b),
    .add_valid_o(add_valid), .add_grant_o(add_grant), .add_opa_o(add_opa), .add_opb_o(add_opb),
    .mul_valid_o(mul_valid), .mul_grant_o(mul_grant), .mul_opa_o(mul_opa), .mul_opb_o(mul_opb),
    .squash_o(squash), .drop_o(drop), .oversub_o(oversub)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  typedef struct packed {
    logic [NS-1:0]    v;
    logic [2*NS-1:0]  k;
    logic [PW*NS-1:0] g;
    logic [NA*NS-1:0] eag;
    logic [NM*NS-1:0] emg;
    logic [NS-1:0]    esq;
    logic [NS-1:0]    edr;
    logic             eov;
  } vec_t;

  // kind: 0 add, 1 mul, 3 no-op; p0/p1 true, p2 false; slot 3 leftmost
  localparam vec_t VECS [7] = '{
    '{4'b1111, 8'h00, {3'd0,3'd0,3'd0,3'd0}, 8'b0010_0001, 4'b0000, 4'b0000, 4'b1100, 1'b1},
    '{4'b1111, 8'h00, {3'd0,3'd2,3'd1,3'd2}, 8'b1000_0010, 4'b0000, 4'b0101, 4'b0000, 1'b0},
    '{4'b0111, {2'd0,2'd0,2'd1,2'd1}, {3'd0,3'd0,3'd1,3'd0}, 8'b0000_0100, 4'b0001, 4'b0000, 4'b0010, 1'b1},
    '{4'b1111, {2'd0,2'd3,2'd1,2'd1}, {3'd1,3'd0,3'd1,3'd2}, 8'b0000_1000, 4'b0010, 4'b0001, 4'b0000, 1'b0},
    '{4'b0000, 8'h00, {3'd2,3'd2,3'd2,3'd2}, 8'b0000_0000, 4'b0000, 4'b0000, 4'b0000, 1'b0},
    '{4'b1111, {2'd1,2'd0,2'd1,2'd0}, {3'd2,3'd2,3'd2,3'd2}, 8'b0000_0000, 4'b0000, 4'b1111, 4'b0000, 1'b0},
    '{4'b1111, {2'd0,2'd1,2'd0,2'd1}, {3'd0,3'd0,3'd2,3'd1}, 8'b0000_1000, 4'b0001, 4'b0010, 4'b0100, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear();
    v = '0; k = '0; g = '0; dt = '0; df = '0; c = '0; a = '0; b = '0;
  endtask

  task automatic slot(input int s, input logic [1:0] kind, input logic [2:0] gd,
                      input logic [2:0] t, input logic [2:0] f,
                      input logic [7:0] oa, input logic [7:0] ob, input logic cm);
    v[s] = 1'b1; k[2*s +: 2] = kind; g[PW*s +: PW] = gd;
    dt[PW*s +: PW] = t; df[PW*s +: PW] = f;
    a[DW*s +: DW] = oa; b[DW*s +: DW] = ob; c[s] = cm;
  endtask

  // present the staged bundle for one cycle; outputs are read one cycle later
  task automatic step();
    @(negedge clk);
    clear();
  endtask

  task automatic idle();
    clear();
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clear();
    repeat (3) @(negedge clk);
    chk("R1", "add_valid in reset", 32'(add_valid), 0);
    chk("R1", "squash in reset", 32'(squash), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "oversub after reset", 32'(oversub), 0);
    chk("R1", "mul_valid after reset", 32'(mul_valid), 0);
    // R1: p3 reads false after reset
    slot(0, 2'd0, 3'd3, 0, 0, 8'h01, 8'h02, 0);
    step();
    chk("R1", "p3 false after reset", 32'(squash), 32'b0001);

    // R4: equal compare sets p1=1, p2=0
    slot(0, 2'd2, 3'd0, 3'd1, 3'd2, 8'h05, 8'h05, 0);
    step();
    idle();
    slot(0, 2'd0, 3'd1, 0, 0, 8'h11, 8'h22, 0);
    slot(1, 2'd0, 3'd2, 0, 0, 8'h33, 8'h44, 0);
    step();
    chk("R4", "taken/not-taken grant", 32'(add_grant), 32'b0000_0001);
    chk("R4", "taken/not-taken squash", 32'(squash), 32'b0010);
    chk("R7", "unit0 operand a", 32'(add_opa[7:0]), 32'h11);

    // R2 R7 R8 R9 R10: table walk
    for (int i = 0; i < 7; i++) begin
      clear();
      for (int s = 0; s < NS; s++) begin
        if (VECS[i].v[s])
          slot(s, VECS[i].k[2*s +: 2], VECS[i].g[PW*s +: PW], 0, 0, 8'(8'h10 + s), 8'(8'h20 + s), 0);
      end
      step();
      chk("R7", $sformatf("vec%0d add_grant", i), 32'(add_grant), 32'(VECS[i].eag));
      chk("R7", $sformatf("vec%0d mul_grant", i), 32'(mul_grant), 32'(VECS[i].emg));
      chk("R2", $sformatf("vec%0d squash", i), 32'(squash), 32'(VECS[i].esq));
      chk("R9", $sformatf("vec%0d drop", i), 32'(drop), 32'(VECS[i].edr));
      chk("R9", $sformatf("vec%0d oversub", i), 32'(oversub), 32'(VECS[i].eov));
      for (int u = 0; u < NA; u++) begin
        chk("R8", $sformatf("vec%0d add_valid%0d", i, u), 32'(add_valid[u]),
            32'(|VECS[i].eag[u*NS +: NS]));
        for (int s = 0; s < NS; s++) begin
          if (VECS[i].eag[u*NS + s]) begin
            chk("R7", $sformatf("vec%0d add opa%0d", i, u), 32'(add_opa[u*DW +: DW]), 32'(8'h10 + s));
            chk("R7", $sformatf("vec%0d add opb%0d", i, u), 32'(add_opb[u*DW +: DW]), 32'(8'h20 + s));
          end
        end
      end
      for (int s = 0; s < NS; s++) begin
        if (VECS[i].emg[s])
          chk("R7", $sformatf("vec%0d mul opa", i), 32'(mul_opa), 32'(8'h10 + s));
      end
    end

    // R6: unsigned less 1<2 sets p3=1, p4=0; visible two bundles later
    slot(0, 2'd2, 3'd0, 3'd3, 3'd4, 8'h01, 8'h02, 1);
    step();
    chk("R10", "pdef claims nothing", 32'({add_valid, mul_valid, squash}), 0);
    slot(0, 2'd0, 3'd3, 0, 0, 8'h01, 8'h01, 0);
    step();
    chk("R6", "N+1 sees old p3", 32'(squash), 32'b0001);
    slot(0, 2'd0, 3'd3, 0, 0, 8'h01, 8'h01, 0);
    slot(1, 2'd0, 3'd4, 0, 0, 8'h01, 8'h01, 0);
    step();
    chk("R6", "N+2 sees new p3 grant", 32'(add_grant), 32'b0000_0001);
    chk("R6", "N+2 sees new p4 squash", 32'(squash), 32'b0010);

    // R5: set p5=1, p7=1, then a false-guarded define clears both
    slot(0, 2'd2, 3'd0, 3'd5, 3'd6, 8'h03, 8'h03, 0);
    slot(1, 2'd2, 3'd0, 3'd6, 3'd7, 8'h01, 8'h02, 0);
    step();
    idle();
    slot(0, 2'd0, 3'd5, 0, 0, 0, 0, 0);
    slot(1, 2'd0, 3'd7, 0, 0, 0, 0, 0);
    step();
    chk("R5", "p5 p7 true before", 32'(add_grant), 32'b0010_0001);
    slot(0, 2'd2, 3'd2, 3'd5, 3'd7, 8'h04, 8'h04, 0);
    step();
    idle();
    slot(0, 2'd0, 3'd5, 0, 0, 0, 0, 0);
    slot(1, 2'd0, 3'd7, 0, 0, 0, 0, 0);
    step();
    chk("R5", "false guard clears both", 32'(squash), 32'b0011);

    // R3: write to p0 ignored, p6 set
    slot(0, 2'd2, 3'd0, 3'd0, 3'd6, 8'h01, 8'h02, 0);
    step();
    idle();
    slot(0, 2'd0, 3'd0, 0, 0, 0, 0, 0);
    slot(1, 2'd0, 3'd6, 0, 0, 0, 0, 0);
    step();
    chk("R3", "p0 stays true", 32'(add_grant), 32'b0010_0001);
    chk("R3", "no squash", 32'(squash), 0);

    // R11: slot0 writes p3=0, slot1 writes p3=1 (higher wins); slot2 t=1/f=0 to p6 (f wins)
    slot(0, 2'd2, 3'd0, 3'd4, 3'd3, 8'h09, 8'h09, 0);
    slot(1, 2'd2, 3'd0, 3'd5, 3'd3, 8'h01, 8'h02, 0);
    slot(2, 2'd2, 3'd0, 3'd6, 3'd6, 8'h07, 8'h07, 0);
    step();
    idle();
    slot(0, 2'd0, 3'd3, 0, 0, 0, 0, 0);
    slot(1, 2'd0, 3'd6, 0, 0, 0, 0, 0);
    slot(2, 2'd0, 3'd4, 0, 0, 0, 0, 0);
    step();
    chk("R11", "write order grant", 32'(add_grant), 32'b0100_0001);
    chk("R11", "write order squash", 32'(squash), 32'b0010);

    // R10: define and no-op beside two adds
    slot(0, 2'd2, 3'd0, 3'd7, 3'd7, 8'h02, 8'h02, 0);
    slot(1, 2'd0, 3'd0, 0, 0, 0, 0, 0);
    slot(2, 2'd0, 3'd0, 0, 0, 0, 0, 0);
    slot(3, 2'd3, 3'd0, 0, 0, 0, 0, 0);
    step();
    chk("R10", "adds packed past define", 32'(add_grant), 32'b0100_0010);
    chk("R10", "no drop or squash", 32'({drop, squash, oversub}), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule